// File: doc/BRIEF.md
# External Memory Bus Multiplexer

This block turns single access requests from a CPU core into activity on a multiplexed external memory bus. It handles three kinds of request: instruction fetches, data reads and data writes. A low byte port is shared in time. It carries the low address byte in the first phase of an access and the data byte in the two phases after it. A high byte port carries either the high address byte or the value held in a port latch register. Separate active-low strobes mark program fetches, data reads and data writes. An address-latch pulse marks the address phase.

A fetch is routed to internal program memory when the strap input is high and the address is below a programmable limit (default 0x2000). Such a fetch causes no bus activity. It completes with a response flagged as internal. When the strap is low, every fetch goes out on the bus. Data accesses come in two forms. The wide form uses a 16-bit pointer and puts its high byte on the high port. The narrow form uses an 8-bit register as the address, and the high port keeps driving the port latch value.

The bus phases are paced by an oscillator-period strobe from the timing generator. Requests use a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken in any cycle where `req_valid` and `req_ready` are both high. While the block is busy the request inputs are ignored, so the requester must hold them until they are taken. The response is a single-cycle pulse on `rsp_valid` and cannot be back-pressured.

Top module: `xbus_mux`

## Requirements
- R1: When `strap_int` is 1, a fetch (req_kind 0) with address below 0x2000 is internal. The block is busy for one cycle and then gives a response pulse with `rsp_internal`=1 and `rsp_data`=0. While it does so, `ale` stays 0, `psen_n` stays 1 and `lo_oe` stays 0. A fetch at 0x2000 or above goes to the bus.
- R2: When `strap_int` is 0, every fetch goes to the bus, whatever its address.
- R3: A bus access has three phases: address, strobe and capture. In the address phase `ale`=1, `lo_oe`=1 and `lo_out` carries the low address byte. In the strobe and capture phases `ale`=0.
- R4: During a fetch or a wide data access (req_wide=1), `hi_out` carries the high address byte. During a narrow data access (req_wide=0), and while idle, `hi_out` carries `port_latch`.
- R5: `psen_n` is 0 only in the strobe and capture phases of a bus fetch. It stays 1 during data accesses, internal fetches and idle. At most one of `psen_n`, `rd_n` and `wr_n` is low at a time.
- R6: For a data read (req_kind 1, and code 3 behaves the same), `rd_n`=0 and `lo_oe`=0 in the strobe and capture phases. `lo_in` is sampled at the end of the capture phase and returned on `rsp_data`. A bus fetch returns its byte the same way.
- R7: For a data write (req_kind 2), `wr_n`=0, `lo_oe`=1 and `lo_out` equals the write byte in the strobe and capture phases. The response carries `rsp_data`=0.
- R8: Whenever the low port carries an address (`ale`=1), it is driven (`lo_oe`=1).
- R9: `busy` is high from the cycle after a request is taken until its response, and `req_ready` equals not `busy`. A request offered while busy is dropped: it never appears on the bus.
- R10: A bus access leaves a phase only on a cycle with `osc_tick`=1. Otherwise it holds its phase.
- R11: `rsp_valid` pulses for exactly one cycle per completed request, in the cycle after the last phase ends. `rsp_internal` is 0 for bus accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | Oscillator-period strobe that advances bus phases |
| strap_int | input | 1 | 1 lets low fetch addresses use internal program memory |
| port_latch | input | 8 | Port latch register value for the high port |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request (idle) |
| req_kind | input | 2 | 0 fetch, 1 data read, 2 data write, 3 data read |
| req_wide | input | 1 | Data access uses a 16-bit pointer |
| req_addr | input | 16 | Fetch or data address |
| req_wdata | input | 8 | Write byte |
| lo_in | input | 8 | Byte read from the low port |
| lo_out | output | 8 | Byte driven on the low port |
| lo_oe | output | 1 | Low port drive enable |
| hi_out | output | 8 | High port byte |
| ale | output | 1 | Address latch pulse |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Captured byte |
| rsp_internal | output | 1 | Completed fetch was internal |

## Verification
The embedded assertions check, on every cycle, that the three strobes never overlap and that an address on the low port is always driven. They also check that the port is released while a read strobe is low, that phases hold without the oscillator strobe, that a held request stays frozen while busy, and that responses are single pulses. The bench scenarios are needed for the rest. They show the routing decision at the 0x1FFF/0x2000 boundary and under a low strap, and the selection between the high address byte and the latch value. They also show the exact phase-by-phase values on the low port, the captured read byte, and that a request offered while busy never starts an access.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_RD    = 2'd1,
    K_WR    = 2'd2
  } xkind_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RESP = 3'd1,
    S_ADR  = 3'd2,
    S_STB  = 3'd3,
    S_CAP  = 3'd4
  } xphase_t;
endpackage

// File: rtl/xbus_route.sv
module xbus_route
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int INT_LIMIT = 16'h2000
) (
  input  xkind_t          kind,
  input  logic [AW-1:0]   addr,
  input  logic            strap_int,
  output logic            go_internal
);
  localparam logic [AW-1:0] LIMIT = AW'(INT_LIMIT);

  always_comb begin
    go_internal = (kind == K_FETCH) && strap_int && (addr < LIMIT);
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic          req_valid,
  input  xkind_t        req_kind,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          go_internal,
  input  logic [DW-1:0] lo_in,
  output logic          req_ready,
  output logic          busy,
  output xphase_t       phase,
  output xkind_t        cap_kind,
  output logic          cap_wide,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_internal
);
  logic accept;

  assign busy      = (phase != S_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && (phase == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= S_IDLE;
      cap_kind     <= K_FETCH;
      cap_wide     <= 1'b0;
      cap_addr     <= '0;
      cap_wdata    <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_internal <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (phase)
        S_IDLE: if (accept) begin
          cap_kind  <= req_kind;
          cap_wide  <= req_wide;
          cap_addr  <= req_addr;
          cap_wdata <= req_wdata;
          phase     <= go_internal ? S_RESP : S_ADR;
        end
        S_RESP: begin
          phase        <= S_IDLE;
          rsp_valid    <= 1'b1;
          rsp_internal <= 1'b1;
          rsp_data     <= '0;
        end
        S_ADR: if (osc_tick) phase <= S_STB;
        S_STB: if (osc_tick) phase <= S_CAP;
        S_CAP: if (osc_tick) begin
          phase        <= S_IDLE;
          rsp_valid    <= 1'b1;
          rsp_internal <= 1'b0;
          rsp_data     <= (cap_kind == K_WR) ? '0 : lo_in;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  // R10: bus phases only move on an oscillator strobe
  a_r10_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_tick && (phase == S_ADR || phase == S_STB || phase == S_CAP)) |=> $stable(phase));

  // R9: a request offered while busy leaves the held request untouched
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cap_addr) && $stable(cap_kind));

  // R11: completion is a single-cycle pulse
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xphase_t          phase,
  input  xkind_t           cap_kind,
  input  logic             cap_wide,
  input  logic [AW-1:0]    cap_addr,
  input  logic [DW-1:0]    cap_wdata,
  input  logic [AW-DW-1:0] port_latch,
  output logic [DW-1:0]    lo_out,
  output logic             lo_oe,
  output logic [AW-DW-1:0] hi_out,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n
);
  logic on_bus, in_strobe, is_wr;

  always_comb begin
    on_bus    = (phase == S_ADR) || (phase == S_STB) || (phase == S_CAP);
    in_strobe = (phase == S_STB) || (phase == S_CAP);
    is_wr     = (cap_kind == K_WR);

    ale    = (phase == S_ADR);
    lo_oe  = (phase == S_ADR) || (in_strobe && is_wr);
    if (phase == S_ADR)        lo_out = cap_addr[DW-1:0];
    else if (in_strobe && is_wr) lo_out = cap_wdata;
    else                       lo_out = '0;

    if (on_bus && (cap_kind == K_FETCH || cap_wide)) hi_out = cap_addr[AW-1:DW];
    else                                              hi_out = port_latch;

    psen_n = !(in_strobe && cap_kind == K_FETCH);
    rd_n   = !(in_strobe && cap_kind == K_RD);
    wr_n   = !(in_strobe && is_wr);
  end

  // R5: strobes never overlap
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  // R8: an address on the low port is always actively driven
  a_r8_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> lo_oe);

  // R6: the low port is released while a read strobe is active
  a_r6_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !lo_oe);
endmodule

// File: rtl/xbus_mux.sv
module xbus_mux
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int INT_LIMIT = 16'h2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             strap_int,
  input  logic [AW-DW-1:0] port_latch,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic             req_wide,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [DW-1:0]    lo_in,
  output logic [DW-1:0]    lo_out,
  output logic             lo_oe,
  output logic [AW-DW-1:0] hi_out,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             busy,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_internal
);
  xkind_t          kind_in, cap_kind;
  xphase_t         phase;
  logic            go_internal, cap_wide;
  logic [AW-1:0]   cap_addr;
  logic [DW-1:0]   cap_wdata;

  assign kind_in = (req_kind == 2'd3) ? K_RD : xkind_t'(req_kind);

  xbus_route #(.AW(AW), .INT_LIMIT(INT_LIMIT)) u_route (
    .kind(kind_in), .addr(req_addr), .strap_int(strap_int), .go_internal(go_internal)
  );

  xbus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .req_valid(req_valid), .req_kind(kind_in), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .go_internal(go_internal),
    .lo_in(lo_in), .req_ready(req_ready), .busy(busy), .phase(phase),
    .cap_kind(cap_kind), .cap_wide(cap_wide), .cap_addr(cap_addr),
    .cap_wdata(cap_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_internal(rsp_internal)
  );

  xbus_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cap_kind(cap_kind),
    .cap_wide(cap_wide), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
    .port_latch(port_latch), .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  // R1: an internal completion has produced no bus activity
  a_r1_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_internal) |-> (psen_n && !ale && !lo_oe));
endmodule

// File: tb/sim_xbus_mux.sv
module sim_xbus_mux;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b1, strap_int = 1'b1;
  logic [7:0] port_latch = 8'h5C;
  logic req_valid = 1'b0, req_wide = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, lo_in = '0;
  logic req_ready, lo_oe, ale, psen_n, rd_n, wr_n, busy, rsp_valid, rsp_internal;
  logic [7:0] lo_out, hi_out, rsp_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_mux u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .strap_int(strap_int),
    .port_latch(port_latch), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .lo_in(lo_in), .lo_out(lo_out), .lo_oe(lo_oe),
    .hi_out(hi_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_internal(rsp_internal)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(logic [1:0] k, logic w, logic [15:0] a, logic [7:0] d);
    req_kind = k; req_wide = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
  endtask

  // full three-phase bus access, every phase checked
  task automatic t_bus(logic [1:0] k, logic w, logic [15:0] a, logic [7:0] d, logic [7:0] rbyte);
    logic [7:0] hi_exp;
    logic is_f, is_w;
    is_f = (k == 2'd0);
    is_w = (k == 2'd2);
    hi_exp = (is_f || w) ? a[15:8] : port_latch;
    offer(k, w, a, d);
    check("R3 address phase ale", {15'b0, ale}, 16'd1);
    check("R8 address driven", {15'b0, lo_oe}, 16'd1);
    check("R3 address low byte", {8'b0, lo_out}, {8'b0, a[7:0]});
    check("R4 high port addr phase", {8'b0, hi_out}, {8'b0, hi_exp});
    check("R9 busy during access", {14'b0, busy, req_ready}, 16'b10);
    lo_in = rbyte;
    for (int p = 0; p < 2; p++) begin
      step();
      check("R3 no ale in data phases", {15'b0, ale}, 16'd0);
      check("R5 fetch strobe", {15'b0, psen_n}, {15'b0, !is_f});
      check("R6 read strobe", {15'b0, rd_n}, {15'b0, is_f || is_w});
      check("R7 write strobe", {15'b0, wr_n}, {15'b0, !is_w});
      check("R6 low port enable", {15'b0, lo_oe}, {15'b0, is_w});
      if (is_w) check("R7 write byte", {8'b0, lo_out}, {8'b0, d});
      check("R4 high port data phase", {8'b0, hi_out}, {8'b0, hi_exp});
    end
    step();
    check("R11 response pulse", {14'b0, rsp_valid, rsp_internal}, 16'b10);
    check("R6 response byte", {8'b0, rsp_data}, is_w ? 16'd0 : {8'b0, rbyte});
    check("R4 idle high port", {8'b0, hi_out}, {8'b0, port_latch});
    step();
    check("R11 pulse ends", {15'b0, rsp_valid}, 16'd0);
    check("R5 strobes idle", {13'b0, psen_n, rd_n, wr_n}, 16'b111);
  endtask

  task automatic t_reset();
    check("R9 reset ready", {14'b0, busy, req_ready}, 16'b01);
    check("R5 reset strobes", {12'b0, psen_n, rd_n, wr_n, ale}, 16'b1110);
    check("R3 reset port released", {15'b0, lo_oe}, 16'd0);
    check("R4 reset high port", {8'b0, hi_out}, {8'b0, port_latch});
    check("R11 reset no response", {15'b0, rsp_valid}, 16'd0);
  endtask

  task automatic t_internal(logic [15:0] a);
    strap_int = 1'b1;
    offer(2'd0, 1'b0, a, 8'h00);
    check("R1 internal busy", {15'b0, busy}, 16'd1);
    check("R1 internal no bus", {13'b0, psen_n, ale, lo_oe}, 16'b100);
    step();
    check("R1 internal response", {14'b0, rsp_valid, rsp_internal}, 16'b11);
    check("R1 internal data zero", {8'b0, rsp_data}, 16'd0);
    check("R1 internal psen idle", {14'b0, psen_n, ale}, 16'b10);
    step();
  endtask

  task automatic t_boundary();
    strap_int = 1'b1;
    t_internal(16'h1FFF);
    offer(2'd0, 1'b0, 16'h2000, 8'h00);
    check("R1 limit address goes to bus", {15'b0, ale}, 16'd1);
    repeat (4) step();
  endtask

  task automatic t_strap_low();
    strap_int = 1'b0;
    t_bus(2'd0, 1'b0, 16'h0010, 8'h00, 8'h3B);
    offer(2'd0, 1'b0, 16'h0044, 8'h00);
    check("R2 strap low low fetch on bus", {14'b0, ale, rsp_internal}, 16'b10);
    repeat (4) step();
    strap_int = 1'b1;
  endtask

  task automatic t_busy_ignore();
    offer(2'd0, 1'b0, 16'h4321, 8'h00);
    lo_in = 8'h77;
    step();
    req_kind = 2'd2; req_addr = 16'h00AA; req_wdata = 8'h99; req_valid = 1'b1;
    check("R9 not ready while busy", {15'b0, req_ready}, 16'd0);
    step();
    req_valid = 1'b0;
    step();
    check("R9 original response kept", {8'b0, rsp_data}, 16'h0077);
    step();
    check("R9 dropped request never starts", {14'b0, ale, busy}, 16'b00);
    check("R9 no write after drop", {15'b0, wr_n}, 16'd1);
  endtask

  task automatic t_slow_tick();
    osc_tick = 1'b0;
    offer(2'd1, 1'b1, 16'h9A01, 8'h00);
    step();
    check("R10 address phase held", {15'b0, ale}, 16'd1);
    osc_tick = 1'b1;
    step();
    check("R10 advanced on tick", {14'b0, ale, rd_n}, 16'b00);
    osc_tick = 1'b0;
    lo_in = 8'hE4;
    repeat (3) step();
    check("R10 strobe held without tick", {14'b0, rd_n, rsp_valid}, 16'b00);
    osc_tick = 1'b1;
    step();
    step();
    check("R10 response after ticks", {8'b0, rsp_valid, rsp_data[6:0]}, {8'b0, 1'b1, 7'h64});
    step();
    check("R11 response single", {15'b0, rsp_valid}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_internal(16'h0123);
    t_boundary();
    t_bus(2'd0, 1'b0, 16'h8C45, 8'h00, 8'hA5);
    t_strap_low();
    t_bus(2'd1, 1'b1, 16'hBEEF, 8'h00, 8'h1D);
    t_bus(2'd1, 1'b0, 16'h7733, 8'h00, 8'hC2);
    t_bus(2'd3, 1'b0, 16'h0066, 8'h00, 8'h48);
    t_bus(2'd2, 1'b1, 16'h4E10, 8'h6B, 8'h00);
    port_latch = 8'hD1;
    t_bus(2'd2, 1'b0, 16'h00F0, 8'h2A, 8'h00);
    t_busy_ignore();
    t_slow_tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule